// File: doc/BRIEF.md
# Conversion Auto-Start Trigger Selector

This block decides when a data converter should begin a new conversion without a software request. A small configuration register holds a three-bit code that picks one of eight event flags. The picked flag goes through a rising-edge detector. When both the converter-enable input and the auto-start-enable input are high, each detected edge produces a one-cycle start pulse. A software start request can also produce a pulse. Code 000 picks the conversion-done flag itself, so each finished conversion starts the next one (free-running operation).

The edge is taken after the selection multiplexer. As a result, moving the selection from a low flag to a high flag counts as an edge. The single exception is a move into free-running operation, which never produces a start. While the converter reports busy, edges are dropped and are not stored for later. The converter itself, its sequencing and its result storage sit outside this block.

Top module: `adc_trig_sel`

## Requirements
- R1: While reset is active and in the first cycle after it, the configuration register reads 0 and `start_o` is low.
- R2: A write stores `bus_wdata[2:0]` into the selection field. `bus_rdata` returns that value from the next cycle on. Bits above bit 2 always read zero and ignore what is written to them.
- R3: Selection code k (0 to 7) picks `trig_flags[k]`. Code 0 is the conversion-done flag, 1 the comparator, 2 external event 0, 3 timer-0 match, 4 timer-0 wrap, 5 timer-1 match B, 6 timer-1 wrap and 7 timer-1 capture.
- R4: A low-to-high change of the picked flag, sampled at one clock edge, makes `start_o` high for the following cycle. A flag that stays high produces no further pulse.
- R5: With `auto_en` low, no flag edge produces a start.
- R6: With `adc_en` low, no start is produced, whether from a flag edge or from `man_start`.
- R7: A write that moves the selection from a low flag to a high flag produces a start one cycle after the selection takes effect.
- R8: A write of code 0 never produces a start, even when the conversion-done flag is already high.
- R9: With code 0 selected, `man_start` (enables set, not busy) starts the first conversion, and each later rise of the conversion-done flag starts the next one.
- R10: A flag edge or `man_start` seen while `conv_busy` is high is dropped. No start follows it after busy falls.
- R11: `start_o` is a registered pulse, one cycle wide for each flag edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the configuration register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read data |
| adc_en | input | 1 | Converter enable from the companion control register |
| auto_en | input | 1 | Auto-start enable from the companion control register |
| man_start | input | 1 | Software start request |
| conv_busy | input | 1 | Converter busy with a conversion |
| trig_flags | input | 8 | Candidate trigger flags; bit 0 is conversion done |
| start_o | output | 1 | Conversion start pulse |

## Verification
A flag edge or a `man_start` sampled at rising edge N shows on `start_o` directly after edge N. A selection write at edge N changes `bus_rdata` directly after edge N. The start it causes appears only after edge N+1, because the multiplexer does not see the new code before then. The stimulus changes on the falling edge, and every result is read 1 ns after the next rising edge. Each table row therefore states the result due one clock after its inputs. Rows that follow a write carry the delayed start expectation.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
   localparam int SRC_W   = 3;
   localparam int SRC_NUM = 1 << SRC_W;

   typedef enum logic [SRC_W-1:0] {
      SRC_FREE_RUN  = 3'd0,
      SRC_COMPARE   = 3'd1,
      SRC_EXT_EVT0  = 3'd2,
      SRC_T0_MATCH  = 3'd3,
      SRC_T0_WRAP   = 3'd4,
      SRC_T1_MATCHB = 3'd5,
      SRC_T1_WRAP   = 3'd6,
      SRC_T1_CAPT   = 3'd7
   } trig_src_e;
endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg
   import adc_trig_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output trig_src_e         sel_o,
   output logic              to_free_o,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD_W = DATA_W - SRC_W;

   trig_src_e sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= SRC_FREE_RUN;
      else if (wr)
         sel_q <= trig_src_e'(wdata[SRC_W-1:0]);
   end

   assign to_free_o = wr && (trig_src_e'(wdata[SRC_W-1:0]) == SRC_FREE_RUN);
   assign sel_o     = sel_q;
   assign rdata     = {{PAD_W{1'b0}}, sel_q};
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
   import adc_trig_pkg::*;
#(
   parameter bit AND_OR = 1'b0
) (
   input  logic [SRC_NUM-1:0] flags,
   input  trig_src_e          sel,
   output logic               pick
);
   generate
      if (AND_OR) begin : g_andor
         logic [SRC_NUM-1:0] hit;
         for (genvar i = 0; i < SRC_NUM; i++) begin : g_leg
            assign hit[i] = flags[i] & (sel == trig_src_e'(i));
         end
         assign pick = |hit;
      end else begin : g_index
         assign pick = flags[sel];
      end
   endgenerate
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic resync_i,
   input  logic resync_val_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         prev_q <= 1'b0;
      else if (resync_i)
         prev_q <= resync_val_i;
      else
         prev_q <= src_i;
   end

   assign rise_o = src_i & ~prev_q;
endmodule

// File: rtl/trig_start_gen.sv
module trig_start_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic auto_en,
   input  logic adc_en,
   input  logic man_start,
   input  logic conv_busy,
   output logic start_o
);
   logic req;
   logic start_q;

   assign req = (rise_i & auto_en) | man_start;

   always_ff @(posedge clk) begin
      if (!rst_n)
         start_q <= 1'b0;
      else
         start_q <= req & adc_en & ~conv_busy;
   end

   assign start_o = start_q;
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
   import adc_trig_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit MUX_AND_OR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              adc_en,
   input  logic              auto_en,
   input  logic              man_start,
   input  logic              conv_busy,
   input  logic [SRC_NUM-1:0] trig_flags,
   output logic              start_o
);
   generate
      if (DATA_W <= SRC_W) begin : g_bad_width
         $error("adc_trig_sel: DATA_W must exceed the selection width");
      end
   endgenerate

   trig_src_e sel;
   logic      to_free;
   logic      picked;
   logic      rise;

   trig_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
      .sel_o(sel), .to_free_o(to_free), .rdata(bus_rdata)
   );

   trig_src_mux #(.AND_OR(MUX_AND_OR)) u_mux (
      .flags(trig_flags), .sel(sel), .pick(picked)
   );

   // On a move to free running, the delayed copy takes the done flag itself
   trig_edge_det u_edge (
      .clk(clk), .rst_n(rst_n), .src_i(picked),
      .resync_i(to_free), .resync_val_i(trig_flags[0]), .rise_o(rise)
   );

   trig_start_gen u_start (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .auto_en(auto_en),
      .adc_en(adc_en), .man_start(man_start), .conv_busy(conv_busy),
      .start_o(start_o)
   );
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              adc_en,
   input logic              auto_en,
   input logic              man_start,
   input logic              conv_busy,
   input logic [7:0]        trig_flags,
   input logic              start_o
);
   a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:3] == '0);

   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wr) |-> bus_rdata[2:0] == $past(bus_wdata[2:0]));

   a_r5_auto_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && !$past(man_start)) |-> $past(auto_en));

   a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(adc_en));

   a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !$past(conv_busy));

   a_r8_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wdata[2:0] == 3'd0 && !man_start)
      ##1 ($stable(trig_flags[0]) && !man_start) |=> !start_o);
endmodule

bind adc_trig_sel adc_trig_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .adc_en(adc_en), .auto_en(auto_en),
   .man_start(man_start), .conv_busy(conv_busy), .trig_flags(trig_flags),
   .start_o(start_o)
);

// File: tb/sim_adc_trig_sel.sv
module sim_adc_trig_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       adc_en = 1'b0, auto_en = 1'b0, man_start = 1'b0, conv_busy = 1'b0;
   logic [7:0] trig_flags = 8'h00;
   logic       start_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   adc_trig_sel u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .adc_en(adc_en), .auto_en(auto_en),
      .man_start(man_start), .conv_busy(conv_busy), .trig_flags(trig_flags),
      .start_o(start_o)
   );

   typedef struct packed {
      logic       wr;
      logic [7:0] wd;
      logic [7:0] fl;
      logic       au, en, mn, bz;
      logic       es;
      logic [2:0] er;
      logic [3:0] rq;
   } row_t;

   function automatic row_t mk(logic wr, logic [7:0] wd, logic [7:0] fl,
                               logic au, logic en, logic mn, logic bz,
                               logic es, logic [2:0] er, logic [3:0] rq);
      mk = '{wr, wd, fl, au, en, mn, bz, es, er, rq};
   endfunction

   localparam int N = 36;
   localparam row_t TBL [N] = '{
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd0, 4'd4),   // idle
      mk(0, 8'h00, 8'h00, 1,1,1,0, 1, 3'd0, 4'd9),   // R9 manual first start
      mk(0, 8'h00, 8'h00, 1,1,0,1, 0, 3'd0, 4'd10),  // busy
      mk(0, 8'h00, 8'h01, 1,1,0,0, 1, 3'd0, 4'd9),   // R9 done flag rises
      mk(0, 8'h00, 8'h01, 1,1,0,0, 0, 3'd0, 4'd11),  // R11 held high
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd0, 4'd4),
      mk(1, 8'hF9, 8'h00, 1,1,0,0, 0, 3'd1, 4'd2),   // R2 reserved bits dropped
      mk(0, 8'h00, 8'h02, 1,1,0,0, 1, 3'd1, 4'd3),   // R3 comparator
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd1, 4'd4),
      mk(0, 8'h00, 8'h02, 0,1,0,0, 0, 3'd1, 4'd5),   // R5 auto off
      mk(0, 8'h00, 8'h02, 1,1,0,0, 0, 3'd1, 4'd4),   // R4 level gives nothing
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd1, 4'd4),
      mk(0, 8'h00, 8'h02, 1,0,0,0, 0, 3'd1, 4'd6),   // R6 converter off
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd1, 4'd4),
      mk(0, 8'h00, 8'h02, 1,1,0,1, 0, 3'd1, 4'd10),  // R10 edge while busy
      mk(0, 8'h00, 8'h02, 1,1,0,0, 0, 3'd1, 4'd10),  // R10 not queued
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd1, 4'd4),
      mk(0, 8'h00, 8'h04, 1,1,0,0, 0, 3'd1, 4'd3),   // unselected flag rises
      mk(1, 8'h02, 8'h04, 1,1,0,0, 0, 3'd2, 4'd7),   // select high source
      mk(0, 8'h00, 8'h04, 1,1,0,0, 1, 3'd2, 4'd7),   // R7 switch edge
      mk(1, 8'h00, 8'h05, 1,1,0,0, 0, 3'd0, 4'd8),   // to free running
      mk(0, 8'h00, 8'h05, 1,1,0,0, 0, 3'd0, 4'd8),   // R8
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd0, 4'd4),
      mk(1, 8'h07, 8'h00, 1,1,0,0, 0, 3'd7, 4'd2),
      mk(0, 8'h00, 8'h80, 1,1,0,0, 1, 3'd7, 4'd3),   // R3 capture
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd7, 4'd4),
      mk(1, 8'h03, 8'h08, 1,1,0,0, 0, 3'd3, 4'd7),
      mk(0, 8'h00, 8'h08, 1,1,0,0, 1, 3'd3, 4'd7),   // R7 timer-0 match
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd3, 4'd4),
      mk(0, 8'h00, 8'h00, 1,1,1,1, 0, 3'd3, 4'd10),  // R10 manual while busy
      mk(0, 8'h00, 8'h00, 1,0,1,0, 0, 3'd3, 4'd6),   // R6 manual, disabled
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd3, 4'd4),
      mk(0, 8'h00, 8'h01, 1,1,0,0, 0, 3'd3, 4'd3),   // done high, unselected
      mk(1, 8'h00, 8'h01, 1,1,0,0, 0, 3'd0, 4'd8),   // low -> high into code 0
      mk(0, 8'h00, 8'h01, 1,1,0,0, 0, 3'd0, 4'd8),   // R8 no start
      mk(0, 8'h00, 8'h00, 1,1,0,0, 0, 3'd0, 4'd4)
   };

   task automatic check(string rq, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 rdata in reset", bus_rdata, 8'h00);
      check("R1 start in reset", {7'b0, start_o}, 8'h00);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 rdata after reset", bus_rdata, 8'h00);
      check("R1 start after reset", {7'b0, start_o}, 8'h00);

      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         bus_wr = TBL[i].wr;  bus_wdata = TBL[i].wd; trig_flags = TBL[i].fl;
         auto_en = TBL[i].au; adc_en = TBL[i].en;    man_start = TBL[i].mn;
         conv_busy = TBL[i].bz;
         @(posedge clk); #1;
         check($sformatf("R%0d row %0d start", TBL[i].rq, i), {7'b0, start_o}, {7'b0, TBL[i].es});
         check($sformatf("R%0d row %0d rdata", TBL[i].rq, i), bus_rdata, {5'b0, TBL[i].er});
      end

      // R1: reset in the middle of a run clears the selection
      @(negedge clk);
      bus_wr = 1'b1; bus_wdata = 8'h05; trig_flags = 8'h00;
      @(negedge clk);
      bus_wr = 1'b0; rst_n = 1'b0;
      @(posedge clk); #1;
      check("R1 mid-run reset rdata", bus_rdata, 8'h00);
      @(negedge clk) rst_n = 1'b1;
      // R3: code 5 after reset picks timer-1 match B
      bus_wr = 1'b1; bus_wdata = 8'h05;
      @(negedge clk);
      bus_wr = 1'b0; trig_flags = 8'h20;
      @(posedge clk); #1;
      check("R3 code 5 start", {7'b0, start_o}, 8'h01);
      @(posedge clk); #1;
      check("R11 pulse one cycle", {7'b0, start_o}, 8'h00);

      done = 1'b1;
      finish_run();
   end
endmodule